// File: doc/BRIEF.md
# SDR SDRAM Single-Port Controller

This block sits between a simple host port and a quad-bank, 16-bit-wide single-data-rate SDRAM with 4,096 rows and 512 columns per bank. After reset it runs the power-up sequence and programs the mode register. It then turns each host request into a complete access of one word. The access opens the row, issues a read or write with self-timed precharge, and waits out the recovery time so the bank is closed again before the next command.

The host offers a request with a write flag, a flat word address and write data, and it may do so only while `host_ready` is high. Read data returns on `host_rdata` with a one-cycle `host_rvalid` strobe after the programmed CAS latency. A free-running interval timer raises a refresh request about every 15.6 µs. The request is served as soon as the controller is idle, and it holds off new host requests until it has been served.

Top module: `sdr_ctrl`

## Requirements
- R1: From reset until initialization ends, `host_ready` is low, the command pins carry NOP ({cs_n,ras_n,cas_n,we_n} = 0111) except for the init commands, `sd_dqm` is all ones and `sd_dq_oe` is low.
- R2: Initialization runs in this order: NOP for at least `INIT_CYCLES` clocks, then PRECHARGE (0010) with address bit 10 high, then AUTO REFRESH (0001) twice. The PRECHARGE is followed by at least `TRP` clocks, and each AUTO REFRESH by at least `TRC` clocks.
- R3: The LOAD MODE REGISTER command (0000) drives bank 0 and an address word with bits 6:4 equal to the CAS latency and bits 2:0 equal to zero (one-word bursts, sequential order).
- R4: `host_ready` first rises exactly `TMRD` clocks after the LOAD MODE REGISTER command.
- R5: Every access issues ACTIVE (0011) and then, no sooner than `TRCD` clocks later, READ (0101) or WRITE (0100) to the same bank, with address bit 10 high (auto precharge).
- R6: The write word appears on `sd_dq_out` with `sd_dq_oe` high and `sd_dqm` zero only in the WRITE cycle. `sd_dq_oe` is low in every other cycle.
- R7: The word on `sd_dq_in` at the clock edge `CAS_LAT` cycles after the READ edge is returned on `host_rdata`, with `host_rvalid` high for exactly one cycle.
- R8: The host address splits as column = bits 8:0, bank = bits 10:9 and row = bits 22:11. The row goes out with ACTIVE and the column with READ/WRITE.
- R9: A new ACTIVE comes at least `TRC` clocks after the previous ACTIVE, at least `TWR+TRP` clocks after a WRITE and at least `CAS_LAT+TRP` clocks after a READ.
- R10: After init, one AUTO REFRESH is due every `REF_INTERVAL` clocks. A pending refresh holds `host_ready` low and is issued only with all banks closed. When idle, successive refreshes are exactly `REF_INTERVAL` apart, and an access delays a refresh by at most a few clocks.
- R11: A request is taken only while `host_ready` is high. A request raised while the controller is busy produces no command and changes no memory word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything is sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | Access request, taken while host_ready is high |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 23 | Word address {row, bank, column} |
| host_wdata | input | 16 | Write word |
| host_ready | output | 1 | Controller can take a request this cycle |
| host_rdata | output | 16 | Read word |
| host_rvalid | output | 1 | One-cycle strobe marking host_rdata valid |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe command bit, active low |
| sd_cas_n | output | 1 | Column strobe command bit, active low |
| sd_we_n | output | 1 | Write-enable command bit, active low |
| sd_ba | output | 2 | Bank select |
| sd_addr | output | 12 | Row, column or mode word |
| sd_dqm | output | 2 | Byte data masks |
| sd_dq_out | output | 16 | Data toward the memory |
| sd_dq_oe | output | 1 | Drive enable for sd_dq_out |
| sd_dq_in | input | 16 | Data from the memory |

## Verification
The hardest case to reach from the ports is a refresh interval that expires while an access is already in flight. The refresh must then wait until the bank has precharged, and it must still land before the next host access. The stimulus streams back-to-back write/read pairs for several refresh intervals, so expiries fall at many different offsets inside accesses. A bus model then checks that every refresh meets closed banks and that no gap between refreshes grows past the interval plus a short slack.

// File: rtl/sdr_ctrl_pkg.sv
package sdr_ctrl_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LMR = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } sdr_cmd_e;

  // mode word: one-word burst, sequential, latency in bits 6:4
  function automatic logic [11:0] mode_word(int cl);
    return {5'b00000, cl[2:0], 4'b0000};
  endfunction

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // clocks from READ to the next command
  function automatic int rd_gap(int cl, int trp, int trc, int trcd);
    return max2(cl + trp, trc - trcd);
  endfunction

  // clocks from WRITE to the next command
  function automatic int wr_gap(int twr, int trp, int trc, int trcd);
    return max2(twr + trp, trc - trcd);
  endfunction

endpackage

// File: rtl/sdr_refresh_timer.sv
module sdr_refresh_timer #(
  parameter int INTERVAL = 1560
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic ack,
  output logic pending
);
  localparam int CW = $clog2(INTERVAL + 1);

  logic [CW-1:0] count;
  logic          expire;

  assign expire = run && (count == CW'(INTERVAL - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      pending <= 1'b0;
    end else begin
      if (run) count <= expire ? '0 : count + 1'b1;
      if (expire)   pending <= 1'b1;
      else if (ack) pending <= 1'b0;
    end
  end
endmodule

// File: rtl/sdr_read_pipe.sv
module sdr_read_pipe #(
  parameter int CAS_LAT = 2,
  parameter int DQ_W    = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue,
  input  logic [DQ_W-1:0] dq_in,
  output logic [DQ_W-1:0] rdata,
  output logic            rvalid
);
  logic [CAS_LAT-1:0] flight;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flight <= '0;
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      flight <= (flight << 1) | CAS_LAT'(issue);
      rvalid <= flight[CAS_LAT-1];
      if (flight[CAS_LAT-1]) rdata <= dq_in;
    end
  end
endmodule

// File: rtl/sdr_cmd_fsm.sv
module sdr_cmd_fsm
  import sdr_ctrl_pkg::*;
#(
  parameter int ROW_W       = 12,
  parameter int BANK_W      = 2,
  parameter int COL_W       = 9,
  parameter int DQ_W        = 16,
  parameter int INIT_CYCLES = 10000,
  parameter int CAS_LAT     = 2,
  parameter int TRCD        = 2,
  parameter int TRP         = 2,
  parameter int TRC         = 7,
  parameter int TMRD        = 2,
  parameter int TWR         = 2,
  localparam int ADDR_W     = ROW_W + BANK_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DQ_W-1:0]   host_wdata,
  input  logic              ref_pending,
  output logic              host_ready,
  output sdr_cmd_e          cmd,
  output logic [BANK_W-1:0] ba,
  output logic [ROW_W-1:0]  a,
  output logic [DQ_W-1:0]   dq_out,
  output logic              dq_oe,
  output logic [DQ_W/8-1:0] dqm,
  output logic              init_done,
  output logic              ref_ack,
  output logic              rd_issue
);
  localparam int RD_GAP = rd_gap(CAS_LAT, TRP, TRC, TRCD);
  localparam int WR_GAP = wr_gap(TWR, TRP, TRC, TRCD);
  localparam int CNT_W  = $clog2(INIT_CYCLES + RD_GAP + WR_GAP + TRC + 2);
  localparam int BANK_LSB = COL_W;
  localparam int ROW_LSB  = COL_W + BANK_W;

  typedef enum logic [3:0] {
    ST_POWERUP, ST_PRE_ALL, ST_INIT_REF1, ST_INIT_REF2, ST_LOAD_MODE,
    ST_WAIT, ST_IDLE, ST_ACTIVATE, ST_READ, ST_WRITE, ST_REFRESH
  } state_e;

  state_e              state, ret_state;
  logic [CNT_W-1:0]    cnt;
  logic                we_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [DQ_W-1:0]     wdata_q;
  logic [COL_W-1:0]    col_q;
  logic [BANK_W-1:0]   bank_q;
  logic [ROW_W-1:0]    row_q;

  assign col_q  = addr_q[COL_W-1:0];
  assign bank_q = addr_q[ROW_LSB-1:BANK_LSB];
  assign row_q  = addr_q[ADDR_W-1:ROW_LSB];

  assign host_ready = (state == ST_IDLE) && !ref_pending;
  assign dq_out     = wdata_q;
  assign dqm        = init_done ? '0 : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_POWERUP;
      ret_state <= ST_IDLE;
      cnt       <= CNT_W'(INIT_CYCLES - 1);
      init_done <= 1'b0;
      we_q      <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
    end else begin
      unique case (state)
        ST_POWERUP: begin
          if (cnt == '0) state <= ST_PRE_ALL;
          else           cnt   <= cnt - 1'b1;
        end
        ST_PRE_ALL: begin
          cnt <= CNT_W'(TRP - 2); ret_state <= ST_INIT_REF1; state <= ST_WAIT;
        end
        ST_INIT_REF1: begin
          cnt <= CNT_W'(TRC - 2); ret_state <= ST_INIT_REF2; state <= ST_WAIT;
        end
        ST_INIT_REF2: begin
          cnt <= CNT_W'(TRC - 2); ret_state <= ST_LOAD_MODE; state <= ST_WAIT;
        end
        ST_LOAD_MODE: begin
          init_done <= 1'b1;
          cnt <= CNT_W'(TMRD - 2); ret_state <= ST_IDLE; state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (cnt == '0) state <= ret_state;
          else           cnt   <= cnt - 1'b1;
        end
        ST_IDLE: begin
          if (ref_pending) state <= ST_REFRESH;
          else if (host_req) begin
            we_q    <= host_we;
            addr_q  <= host_addr;
            wdata_q <= host_wdata;
            state   <= ST_ACTIVATE;
          end
        end
        ST_ACTIVATE: begin
          cnt <= CNT_W'(TRCD - 2);
          ret_state <= we_q ? ST_WRITE : ST_READ;
          state <= ST_WAIT;
        end
        ST_READ: begin
          cnt <= CNT_W'(RD_GAP - 2); ret_state <= ST_IDLE; state <= ST_WAIT;
        end
        ST_WRITE: begin
          cnt <= CNT_W'(WR_GAP - 2); ret_state <= ST_IDLE; state <= ST_WAIT;
        end
        ST_REFRESH: begin
          cnt <= CNT_W'(TRC - 2); ret_state <= ST_IDLE; state <= ST_WAIT;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd      = CMD_NOP;
    ba       = '0;
    a        = '0;
    dq_oe    = 1'b0;
    ref_ack  = 1'b0;
    rd_issue = 1'b0;
    unique case (state)
      ST_PRE_ALL: begin
        cmd = CMD_PRE;
        a[10] = 1'b1;
      end
      ST_INIT_REF1, ST_INIT_REF2: cmd = CMD_REF;
      ST_REFRESH: begin
        cmd = CMD_REF;
        ref_ack = 1'b1;
      end
      ST_LOAD_MODE: begin
        cmd = CMD_LMR;
        a = ROW_W'(mode_word(CAS_LAT));
      end
      ST_ACTIVATE: begin
        cmd = CMD_ACT;
        ba = bank_q;
        a = row_q;
      end
      ST_READ: begin
        cmd = CMD_RD;
        ba = bank_q;
        a[COL_W-1:0] = col_q;
        a[10] = 1'b1;
        rd_issue = 1'b1;
      end
      ST_WRITE: begin
        cmd = CMD_WR;
        ba = bank_q;
        a[COL_W-1:0] = col_q;
        a[10] = 1'b1;
        dq_oe = 1'b1;
      end
      default: cmd = CMD_NOP;
    endcase
  end
endmodule

// File: rtl/sdr_ctrl.sv
module sdr_ctrl
  import sdr_ctrl_pkg::*;
#(
  parameter int CLK_MHZ      = 100,
  parameter int INIT_CYCLES  = CLK_MHZ * 100,
  parameter int REF_INTERVAL = CLK_MHZ * 156 / 10,
  parameter int CAS_LAT      = 2,
  parameter int TRCD         = 2,
  parameter int TRP          = 2,
  parameter int TRC          = 7,
  parameter int TMRD         = 2,
  parameter int TWR          = 2,
  parameter int ROW_W        = 12,
  parameter int BANK_W       = 2,
  parameter int COL_W        = 9,
  parameter int DQ_W         = 16,
  localparam int ADDR_W      = ROW_W + BANK_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DQ_W-1:0]   host_wdata,
  output logic              host_ready,
  output logic [DQ_W-1:0]   host_rdata,
  output logic              host_rvalid,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BANK_W-1:0] sd_ba,
  output logic [ROW_W-1:0]  sd_addr,
  output logic [DQ_W/8-1:0] sd_dqm,
  output logic [DQ_W-1:0]   sd_dq_out,
  output logic              sd_dq_oe,
  input  logic [DQ_W-1:0]   sd_dq_in
);
  sdr_cmd_e cmd_w;
  logic     init_done;
  logic     ref_pending;
  logic     ref_ack;
  logic     rd_issue;

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_w;

  sdr_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_ref (
    .clk(clk), .rst_n(rst_n), .run(init_done), .ack(ref_ack), .pending(ref_pending)
  );

  sdr_cmd_fsm #(
    .ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W), .DQ_W(DQ_W),
    .INIT_CYCLES(INIT_CYCLES), .CAS_LAT(CAS_LAT), .TRCD(TRCD), .TRP(TRP),
    .TRC(TRC), .TMRD(TMRD), .TWR(TWR)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .ref_pending(ref_pending),
    .host_ready(host_ready), .cmd(cmd_w), .ba(sd_ba), .a(sd_addr),
    .dq_out(sd_dq_out), .dq_oe(sd_dq_oe), .dqm(sd_dqm), .init_done(init_done),
    .ref_ack(ref_ack), .rd_issue(rd_issue)
  );

  sdr_read_pipe #(.CAS_LAT(CAS_LAT), .DQ_W(DQ_W)) u_rpipe (
    .clk(clk), .rst_n(rst_n), .issue(rd_issue), .dq_in(sd_dq_in),
    .rdata(host_rdata), .rvalid(host_rvalid)
  );
endmodule

// File: rtl/sdr_ctrl_checker.sv
module sdr_ctrl_checker #(
  parameter int CAS_LAT = 2,
  parameter int TRCD    = 2,
  parameter int TRC     = 7,
  parameter int ROW_W   = 12,
  parameter int BANK_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        cmd,
  input logic [ROW_W-1:0]  sd_addr,
  input logic [BANK_W-1:0] sd_ba,
  input logic              sd_dq_oe,
  input logic              host_ready,
  input logic              host_rvalid,
  input logic              ref_pending,
  input logic              init_done
);
  localparam logic [3:0] C_LMR = 4'b0000;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_ACT = 4'b0011;
  localparam logic [3:0] C_WR  = 4'b0100;
  localparam logic [3:0] C_RD  = 4'b0101;

  logic [7:0] since_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_act <= '0;
    else if (cmd == C_ACT)   since_act <= 8'd1;
    else if (since_act != '1) since_act <= since_act + 1'b1;
  end

  assert_ready_after_init_R1: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |-> init_done);

  assert_mode_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_LMR) |-> (sd_addr[6:4] == CAS_LAT[2:0] && sd_addr[2:0] == 3'b000 && sd_ba == '0));

  assert_act_to_rw_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_RD || cmd == C_WR) |-> (since_act >= 8'(TRCD)));

  assert_auto_precharge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_RD || cmd == C_WR) |-> sd_addr[10]);

  assert_oe_write_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sd_dq_oe |-> (cmd == C_WR));

  assert_rvalid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    host_rvalid |=> !host_rvalid);

  assert_act_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_ACT) |-> (since_act >= 8'(TRC)));

  assert_refresh_blocks_host_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pending |-> !host_ready);

  assert_refresh_after_row_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_REF) |-> (since_act >= 8'(TRC)));
endmodule

bind sdr_ctrl sdr_ctrl_checker #(
  .CAS_LAT(CAS_LAT), .TRCD(TRCD), .TRC(TRC), .ROW_W(ROW_W), .BANK_W(BANK_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd(cmd_w), .sd_addr(sd_addr), .sd_ba(sd_ba),
  .sd_dq_oe(sd_dq_oe), .host_ready(host_ready), .host_rvalid(host_rvalid),
  .ref_pending(ref_pending), .init_done(init_done)
);

// File: tb/tb_sdr_ctrl.sv
module tb_sdr_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int INIT_C = 200;
  localparam int REF_INT = 400;
  localparam int CL = 3;
  localparam int T_RCD = 2, T_RP = 2, T_RC = 7, T_MRD = 2, T_WR = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hreq = 1'b0, hwe = 1'b0;
  logic [22:0] haddr = '0;
  logic [15:0] hwdata = '0;
  logic host_ready, host_rvalid;
  logic [15:0] host_rdata;
  logic cs_n, ras_n, cas_n, we_n;
  logic [1:0] ba, dqm;
  logic [11:0] sa;
  logic [15:0] dq_out;
  logic dq_oe;
  logic [15:0] dq_in = 16'hDEAD;

  int checks = 0, fails = 0, cyc = 0;
  int t_rst, t_pre = -1, t_ref1 = -1, t_ref2 = -1, t_lmr = -1;
  bit pre_a10 = 0;
  logic [11:0] lmr_a = '1;
  logic [1:0] lmr_b = '1;
  int init_refs = 0, ref_cnt = 0, last_ref = -1, last_gap = 0;
  int t_act = -1000, t_rd = -1000, t_wr = -1000, act_cnt = 0;
  bit open_b [4];
  logic [11:0] open_row [4];
  logic [15:0] mem [int];
  int rd_cnt = 0;
  logic [15:0] rd_val = '0;
  logic [22:0] cur_addr = '0;
  logic [15:0] cur_data = '0;

  sdr_ctrl #(.INIT_CYCLES(INIT_C), .REF_INTERVAL(REF_INT), .CAS_LAT(CL)) dut (
    .clk(clk), .rst_n(rst_n), .host_req(hreq), .host_we(hwe), .host_addr(haddr),
    .host_wdata(hwdata), .host_ready(host_ready), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .sd_cs_n(cs_n), .sd_ras_n(ras_n), .sd_cas_n(cas_n),
    .sd_we_n(we_n), .sd_ba(ba), .sd_addr(sa), .sd_dqm(dqm), .sd_dq_out(dq_out),
    .sd_dq_oe(dq_oe), .sd_dq_in(dq_in)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [39:0] mkv(bit w, int row, int bank, int col, logic [15:0] d);
    return {w, 12'(row), 2'(bank), 9'(col), d};
  endfunction

  localparam logic [39:0] VEC [10] = '{
    mkv(1, 0, 0, 0, 16'h1111),    mkv(1, 4095, 3, 511, 16'hA5A5),
    mkv(1, 17, 1, 256, 16'h0F0F), mkv(1, 17, 2, 3, 16'hFFFF),
    mkv(0, 0, 0, 0, 16'h1111),    mkv(0, 4095, 3, 511, 16'hA5A5),
    mkv(1, 0, 0, 0, 16'h2222),    mkv(0, 0, 0, 0, 16'h2222),
    mkv(0, 17, 2, 3, 16'hFFFF),   mkv(0, 17, 1, 256, 16'h0F0F)
  };

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // bus model, sampled mid-cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_cnt != 0) begin
        if (rd_cnt == 1) dq_in = rd_val;
        rd_cnt--;
      end
      case ({cs_n, ras_n, cas_n, we_n})
        4'b0010: if (t_pre < 0) begin t_pre = cyc; pre_a10 = sa[10]; end
        4'b0001: begin
          if (t_lmr < 0) begin
            init_refs++;
            if (init_refs == 1) t_ref1 = cyc; else t_ref2 = cyc;
          end else begin
            chk(!open_b[0] && !open_b[1] && !open_b[2] && !open_b[3], "R10", "refresh with open bank", 1, 0);
            if (last_ref >= 0) begin
              last_gap = cyc - last_ref;
              chk(last_gap <= REF_INT + 16, "R10", "refresh gap", last_gap, REF_INT);
            end
            last_ref = cyc;
            ref_cnt++;
          end
        end
        4'b0000: begin t_lmr = cyc; lmr_a = sa; lmr_b = ba; end
        4'b0011: begin
          chk(!open_b[ba], "R5", "activate on open bank", 1, 0);
          chk(ba == cur_addr[10:9] && sa == cur_addr[22:11], "R8", "bank/row", {ba, sa}, {cur_addr[10:9], cur_addr[22:11]});
          chk(cyc - t_act >= T_RC, "R9", "ACT-ACT gap", cyc - t_act, T_RC);
          chk(cyc - t_wr >= T_WR + T_RP, "R9", "WR-ACT gap", cyc - t_wr, T_WR + T_RP);
          chk(cyc - t_rd >= CL + T_RP, "R9", "RD-ACT gap", cyc - t_rd, CL + T_RP);
          chk(!dq_oe, "R6", "oe at ACT", dq_oe, 0);
          open_b[ba] = 1; open_row[ba] = sa; t_act = cyc; act_cnt++;
        end
        4'b0101, 4'b0100: begin
          chk(open_b[ba] && cyc - t_act >= T_RCD, "R5", "ACT-RW delay", cyc - t_act, T_RCD);
          chk(sa[10], "R5", "auto precharge bit", sa[10], 1);
          chk(ba == cur_addr[10:9] && sa[8:0] == cur_addr[8:0], "R8", "bank/col", {ba, sa[8:0]}, {cur_addr[10:9], cur_addr[8:0]});
          if (we_n) begin
            chk(!dq_oe, "R6", "oe at READ", dq_oe, 0);
            rd_val = mem.exists({open_row[ba], ba, sa[8:0]}) ? mem[{open_row[ba], ba, sa[8:0]}] : 16'h0000;
            rd_cnt = CL; t_rd = cyc;
          end else begin
            chk(dq_oe && dqm == 2'b00 && dq_out == cur_data, "R6", "write data", dq_out, cur_data);
            mem[{open_row[ba], ba, sa[8:0]}] = dq_out; t_wr = cyc;
          end
          open_b[ba] = 0;
        end
        default: ;
      endcase
    end
  end

  task automatic access(bit w, logic [22:0] ad, logic [15:0] d);
    int n;
    while (!host_ready) @(negedge clk);
    cur_addr = ad; cur_data = d;
    hreq = 1; hwe = w; haddr = ad; hwdata = d;
    @(negedge clk);
    hreq = 0;
    if (!w) begin
      n = 0;
      while (!host_rvalid && n < 40) begin @(negedge clk); n++; end
      chk(cyc - t_rd == CL + 1, "R7", "read latency", cyc - t_rd, CL + 1);
      chk(host_rdata == d, "R7", "read data", host_rdata, d);
      @(negedge clk);
      chk(!host_rvalid, "R7", "rvalid one cycle", host_rvalid, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int a0, r0;
    for (int b = 0; b < 4; b++) open_b[b] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1; t_rst = cyc;
    @(negedge clk);
    chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R1", "reset command", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
    chk(!host_ready && dqm == 2'b11 && !dq_oe, "R1", "reset ready/dqm/oe", {host_ready, dqm, dq_oe}, 3'b110);
    while (!host_ready) @(negedge clk);
    chk(t_pre - t_rst >= INIT_C && pre_a10, "R2", "power-up wait", t_pre - t_rst, INIT_C);
    chk(t_ref1 - t_pre >= T_RP, "R2", "PRE-REF", t_ref1 - t_pre, T_RP);
    chk(t_ref2 - t_ref1 >= T_RC && init_refs == 2, "R2", "REF-REF", t_ref2 - t_ref1, T_RC);
    chk(t_lmr - t_ref2 >= T_RC, "R2", "REF-LMR", t_lmr - t_ref2, T_RC);
    chk(lmr_a[6:4] == 3'(CL) && lmr_a[2:0] == 3'b000 && lmr_b == 2'b00, "R3", "mode word", lmr_a, CL << 4);
    chk(cyc - t_lmr == T_MRD, "R4", "ready after mode", cyc - t_lmr, T_MRD);

    for (int i = 0; i < 10; i++) access(VEC[i][39], VEC[i][38:16], VEC[i][15:0]);

    // R11: request raised while busy is ignored
    a0 = act_cnt;
    access(1, {12'd5, 2'd1, 9'd7}, 16'h5555);
    hreq = 1; hwe = 1; haddr = {12'd9, 2'd2, 9'd9}; hwdata = 16'hBAD0;
    chk(!host_ready, "R11", "busy after accept", host_ready, 0);
    @(negedge clk); @(negedge clk);
    hreq = 0;
    while (!host_ready) @(negedge clk);
    chk(act_cnt == a0 + 1, "R11", "ignored request", act_cnt - a0, 1);
    access(0, {12'd9, 2'd2, 9'd9}, 16'h0000);
    access(0, {12'd5, 2'd1, 9'd7}, 16'h5555);

    // R10: idle refresh spacing
    r0 = ref_cnt;
    while (ref_cnt < r0 + 3) @(negedge clk);
    chk(last_gap == REF_INT, "R10", "idle refresh period", last_gap, REF_INT);

    // R10: refresh expiring inside back-to-back accesses
    r0 = ref_cnt;
    for (int i = 0; i < 80; i++) begin
      access(1, 23'(i * 4099 + 11), 16'(i * 37 + 5));
      access(0, 23'(i * 4099 + 11), 16'(i * 37 + 5));
    end
    chk(ref_cnt - r0 >= 2, "R10", "refreshes during traffic", ref_cnt - r0, 2);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule